// File: doc/BRIEF.md
# Net Fault Injection Unit

This block is placed in series with a single net of an instrumented design and decides, cycle by cycle, what value that net carries downstream. A controller loads a pending configuration made of two fault patterns into staging registers. Later, on separate strobes, it promotes the first pattern and then the second pattern into the active register. The active pattern selects one of six behaviours: pass-through, a constant 0, a constant 1, a one-cycle delay, a single-cycle inversion that models an upset, or pseudo-random data that models an open net.

The random bit comes from a 16-bit maximal-length shift register inside the block. A build parameter can instead take the bit from a source shared across many units. Staging and activation are kept apart so that a new configuration can be loaded while the current pattern keeps running. The switch between patterns then lands on an exact clock edge chosen by the controller.

Top module: `net_fault_unit`

## Requirements
- R1: With active mode code 0 (none), or with the unused codes 6 or 7, `net_out` equals `net_in` in the same cycle.
- R2: Mode code 1 drives `net_out` to a constant 0, and mode code 2 drives it to a constant 1, whatever `net_in` does.
- R3: With mode code 3, `net_out` equals the value `net_in` had at the previous rising clock edge. The delay register clears to 0 in reset.
- R4: With mode code 4, `net_out` is the inverse of `net_in` only during the one cycle that follows the edge where that pattern was activated. After that it passes `net_in` unchanged. Each new activation of a code-4 pattern inverts again for one cycle.
- R5: With mode code 5 in the local-random build, `net_out` is bit 0 of a 16-bit register. Reset loads that register with 16'hACE1. On every edge out of reset it shifts left by one, and bit 0 takes the XOR of bits 15, 13, 12 and 10. The register never holds zero.
- R6: A clock edge with `cfg_we` high stores `cfg_first` and `cfg_second` (3-bit mode codes) into staging. The output is unaffected until an activation strobe is applied.
- R7: An edge with `act_first` high makes the staged first pattern active, and an edge with `act_second` high makes the staged second pattern active. If both are high, the second pattern wins. Activation uses the staged value held before a configuration write on the same edge.
- R8: In the shared-random build (`SHARED_RNG=1`), mode code 5 drives `net_out` from `rnd_ext` in the same cycle.
- R9: Synchronous reset makes the active mode and both staged modes code 0 and disarms the single-cycle inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| net_in | input | 1 | Original net value |
| cfg_we | input | 1 | Write strobe for the staged pair |
| cfg_first | input | 3 | Mode code of the first staged pattern |
| cfg_second | input | 3 | Mode code of the second staged pattern |
| act_first | input | 1 | Activate the staged first pattern |
| act_second | input | 1 | Activate the staged second pattern |
| rnd_ext | input | 1 | Shared random bit, used only when `SHARED_RNG=1` |
| net_out | output | 1 | Possibly faulted net value |

## Verification
The pass-through, stuck, inversion and random results are combinational from the active state, so they are due in the same cycle as the `net_in` value they act on. The delayed value is due one edge after `net_in` is sampled. Configuration writes and activation strobes take effect only in the cycle after the edge that captures them, and a written configuration shows nothing at the output until it is activated. The bench drives every input just after a falling edge and compares the output one nanosecond later. It advances its own arithmetic model only at the rising edge, so each expectation counts exactly the registers between stimulus and result.

// File: rtl/fiu_pkg.sv
package fiu_pkg;

    localparam int MODE_W   = 3;
    localparam int RNG_W    = 16;
    // feedback taps at bit indices 15, 13, 12, 10
    localparam logic [RNG_W-1:0] RNG_TAPS = 16'hB400;
    localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;

    typedef enum logic [MODE_W-1:0] {
        FM_NONE = 3'd0,
        FM_LOW  = 3'd1,
        FM_HIGH = 3'd2,
        FM_LAG  = 3'd3,
        FM_FLIP = 3'd4,
        FM_RAND = 3'd5,
        FM_RSV6 = 3'd6,
        FM_RSV7 = 3'd7
    } fmode_e;

    typedef struct packed {
        fmode_e first;
        fmode_e second;
    } fpair_t;

    localparam fpair_t PAIR_IDLE = '{first: FM_NONE, second: FM_NONE};

    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s,
                                                 input logic [RNG_W-1:0] taps);
        return {s[RNG_W-2:0], ^(s & taps)};
    endfunction

    function automatic logic arms_flip(input fmode_e m);
        return m == FM_FLIP;
    endfunction

endpackage

// File: rtl/fault_lfsr.sv
module fault_lfsr
    import fiu_pkg::*;
#(
    parameter int               W    = RNG_W,
    parameter logic [W-1:0]     TAPS = RNG_TAPS,
    parameter logic [W-1:0]     SEED = RNG_SEED
) (
    input  logic clk,
    input  logic rst,
    output logic rnd_bit
);

    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= rng_step(state_q, TAPS);
    end

    assign rnd_bit = state_q[0];

    // a maximal-length register must never fall into the all-zero lockup state
    assert_rng_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // every edge out of reset moves the old top bits one place up
    assert_rng_shift_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> state_q[W-1:1] == $past(state_q[W-2:0]));

endmodule

// File: rtl/fault_pattern_stage.sv
module fault_pattern_stage
    import fiu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_we,
    input  fpair_t cfg_in,
    input  logic   act_first,
    input  logic   act_second,
    output fmode_e mode_q,
    output logic   flip_hot
);

    fpair_t stage_q;
    fmode_e pick;
    logic   take;

    // staging register: written by the controller, invisible until promoted
    always_ff @(posedge clk) begin
        if (rst)         stage_q <= PAIR_IDLE;
        else if (cfg_we) stage_q <= cfg_in;
    end

    // second strobe has priority over the first
    always_comb begin
        take = act_first | act_second;
        pick = act_second ? stage_q.second : stage_q.first;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= FM_NONE;
            flip_hot <= 1'b0;
        end else if (take) begin
            mode_q   <= pick;
            flip_hot <= arms_flip(pick);
        end else begin
            flip_hot <= 1'b0;
        end
    end

    assert_flip_single_R4: assert property (@(posedge clk) disable iff (rst)
        (flip_hot && !act_first && !act_second) |=> !flip_hot);

    assert_flip_mode_R4: assert property (@(posedge clk) disable iff (rst)
        flip_hot |-> mode_q == FM_FLIP);

    assert_take_second_R7: assert property (@(posedge clk) disable iff (rst)
        act_second |=> mode_q == $past(stage_q.second));

    assert_take_first_R7: assert property (@(posedge clk) disable iff (rst)
        (act_first && !act_second) |=> mode_q == $past(stage_q.first));

    assert_hold_mode_R6: assert property (@(posedge clk) disable iff (rst)
        (!act_first && !act_second) |=> $stable(mode_q));

    assert_reset_idle_R9: assert property (@(posedge clk)
        $past(rst) |-> (mode_q == FM_NONE && !flip_hot && stage_q == PAIR_IDLE));

endmodule

// File: rtl/fault_select.sv
module fault_select
    import fiu_pkg::*;
(
    input  fmode_e mode,
    input  logic   net_in,
    input  logic   net_lag,
    input  logic   flip_hot,
    input  logic   rnd_bit,
    output logic   net_out
);

    always_comb begin
        unique case (mode)
            FM_LOW:  net_out = 1'b0;
            FM_HIGH: net_out = 1'b1;
            FM_LAG:  net_out = net_lag;
            FM_FLIP: net_out = net_in ^ flip_hot;
            FM_RAND: net_out = rnd_bit;
            default: net_out = net_in;
        endcase
    end

endmodule

// File: rtl/net_fault_unit.sv
module net_fault_unit
    import fiu_pkg::*;
#(
    parameter bit                SHARED_RNG = 1'b0,
    parameter logic [RNG_W-1:0]  SEED       = RNG_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              net_in,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_first,
    input  logic [MODE_W-1:0] cfg_second,
    input  logic              act_first,
    input  logic              act_second,
    input  logic              rnd_ext,
    output logic              net_out
);

    fpair_t cfg_pair;
    fmode_e mode_q;
    logic   flip_hot;
    logic   lag_q;
    logic   local_bit;
    logic   rnd_bit;

    assign cfg_pair = '{first: fmode_e'(cfg_first), second: fmode_e'(cfg_second)};

    fault_pattern_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_in     (cfg_pair),
        .act_first  (act_first),
        .act_second (act_second),
        .mode_q     (mode_q),
        .flip_hot   (flip_hot)
    );

    // one-cycle copy of the net for the delay fault
    always_ff @(posedge clk) begin
        if (rst) lag_q <= 1'b0;
        else     lag_q <= net_in;
    end

    generate
        if (SHARED_RNG) begin : g_shared
            assign local_bit = 1'b0;
        end else begin : g_local
            fault_lfsr #(.W(RNG_W), .TAPS(RNG_TAPS), .SEED(SEED)) u_rng (
                .clk     (clk),
                .rst     (rst),
                .rnd_bit (local_bit)
            );
        end
    endgenerate

    assign rnd_bit = SHARED_RNG ? rnd_ext : local_bit;

    fault_select u_sel (
        .mode     (mode_q),
        .net_in   (net_in),
        .net_lag  (lag_q),
        .flip_hot (flip_hot),
        .rnd_bit  (rnd_bit),
        .net_out  (net_out)
    );

    assert_lag_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FM_LAG && !$past(rst)) |-> net_out == $past(net_in));

    assert_stuck_low_R2: assert property (@(posedge clk) disable iff (rst)
        mode_q == FM_LOW |-> !net_out);

    assert_stuck_high_R2: assert property (@(posedge clk) disable iff (rst)
        mode_q == FM_HIGH |-> net_out);

    assert_pass_through_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FM_NONE || mode_q == FM_RSV6 || mode_q == FM_RSV7) |-> net_out == net_in);

    assert_shared_rand_R8: assert property (@(posedge clk) disable iff (rst)
        (SHARED_RNG && mode_q == FM_RAND) |-> net_out == rnd_ext);

endmodule

// File: tb/net_fault_unit_bench.sv
`timescale 1ns/1ps
module net_fault_unit_bench;

    logic       clk = 1'b0;
    logic       rst, net_in, cfg_we, act_first, act_second, rnd_ext;
    logic [2:0] cfg_first, cfg_second;
    logic       out_loc, out_shr;

    int tests = 0;
    int fails = 0;
    int cyc_n = 0;

    // bench model state
    logic [2:0]  m_mode, m_stg1, m_stg2;
    logic        m_flip, m_prev;
    logic [15:0] m_rng;

    always #4 clk = ~clk;

    net_fault_unit u_net_fault_unit (
        .clk(clk), .rst(rst), .net_in(net_in), .cfg_we(cfg_we),
        .cfg_first(cfg_first), .cfg_second(cfg_second),
        .act_first(act_first), .act_second(act_second),
        .rnd_ext(rnd_ext), .net_out(out_loc)
    );

    net_fault_unit #(.SHARED_RNG(1'b1)) u_shared (
        .clk(clk), .rst(rst), .net_in(net_in), .cfg_we(cfg_we),
        .cfg_first(cfg_first), .cfg_second(cfg_second),
        .act_first(act_first), .act_second(act_second),
        .rnd_ext(rnd_ext), .net_out(out_shr)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", tag, cyc_n, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1, 3'd2: return "R2";
            3'd3:       return "R3";
            3'd4:       return "R4";
            3'd5:       return "R5";
            default:    return "R1";
        endcase
    endfunction

    function automatic logic model_out(input logic [2:0] m, input logic d, input logic r);
        case (m)
            3'd1:    return 1'b0;
            3'd2:    return 1'b1;
            3'd3:    return m_prev;
            3'd4:    return m_flip ? ~d : d;
            3'd5:    return r;
            default: return d;
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 3'd0; m_stg1 = 3'd0; m_stg2 = 3'd0;
        m_flip = 1'b0; m_prev = 1'b0; m_rng = 16'hACE1;
    endtask

    // one clock: drive after falling edge, check, then advance model at rising edge
    task automatic cyc(input logic r, input logic we, input logic [2:0] p1, input logic [2:0] p2,
                       input logic a1, input logic a2, input string ctx);
        int h;
        string t;
        cyc_n++;
        h = cyc_n * 37 + (cyc_n >> 2);
        rst = r; cfg_we = we; cfg_first = p1; cfg_second = p2;
        act_first = a1; act_second = a2;
        net_in  = h[1] ^ h[4];
        rnd_ext = h[2] ^ h[5] ^ cyc_n[0];
        #1;
        t = (ctx.len() > 0) ? ctx : mode_tag(m_mode);
        check(t, out_loc, model_out(m_mode, net_in, m_rng[0]));
        if (m_mode == 3'd5) check("R8", out_shr, rnd_ext);
        else                check(t, out_shr, model_out(m_mode, net_in, m_rng[0]));
        @(posedge clk);
        if (r) model_reset();
        else begin
            m_rng  = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
            m_prev = net_in;
            if (a2)      begin m_mode = m_stg2; m_flip = (m_stg2 == 3'd4); end
            else if (a1) begin m_mode = m_stg1; m_flip = (m_stg1 == 3'd4); end
            else         m_flip = 1'b0;
            if (we) begin m_stg1 = p1; m_stg2 = p2; end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string ctx);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, ctx);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; act_first = 1'b0; act_second = 1'b0;
        cfg_first = 3'd0; cfg_second = 3'd0; net_in = 1'b0; rnd_ext = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        // R9: state after reset is pass-through, staged pair idle
        cyc(1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, "R9");
        cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, "R9");
        idle(2, "R9");
        cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, "R9");
        idle(2, "R9");

        // near-exhaustive sweep over every pair of mode codes
        for (int p1 = 0; p1 < 8; p1++) begin
            for (int p2 = 0; p2 < 8; p2++) begin
                cyc(1'b0, 1'b1, p1[2:0], p2[2:0], 1'b0, 1'b0, "");
                idle(2, "R6");
                cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, "R6");
                idle(4, "");
                cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, "");
                idle(4, "");
            end
        end

        // R4: repeated activation of a flip pattern inverts again each time
        cyc(1'b0, 1'b1, 3'd4, 3'd4, 1'b0, 1'b0, "R4");
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, "R4");
            idle(3, "R4");
        end

        // R7: both strobes at once, second pattern wins
        cyc(1'b0, 1'b1, 3'd1, 3'd2, 1'b0, 1'b0, "R7");
        cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, "R7");
        idle(3, "R7");
        // R7: activation on the same edge as a write uses the older staged value
        cyc(1'b0, 1'b1, 3'd3, 3'd5, 1'b1, 1'b0, "R7");
        idle(3, "R7");
        cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, "R7");
        idle(5, "R3");
        cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, "R8");
        idle(12, "");

        // R9: reset in the middle of an active fault returns to pass-through
        cyc(1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, "");
        idle(2, "R9");
        cyc(1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, "R9");
        idle(2, "R9");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule